// File: doc/BRIEF.md
# UART Interrupt Priority and Status Unit

This block sits beside a UART's line, receive, transmit and modem logic and turns their raw condition flags into one prioritized interrupt report. Each of the four sources is gated by its own bit of an interrupt-enable register held inside the block. The highest-priority surviving source is encoded into an 8-bit status word that the CPU reads. The same result drives an active-high interrupt pin, which is gated by a separate output-enable bit.

Level sources track their raw condition and cannot be acknowledged away. The transmit-holding-empty source is different: it is an event latch. Reading the status word while that source is the one reported clears it, so a lower-priority source shows up on the next read. The latch is armed again by a fresh rising edge of the empty condition, or by an enable-register write that turns the source on while the holding register is empty. After reset the transmit-empty source is both enabled and pending.

There is no data stream through the block. The read strobe and the enable-write strobe are single-cycle pulses that are always accepted, with no back-pressure. The status word is combinational from the registered state and the current inputs.

Top module: `uart_irq_status`

## Requirements
- R1: After reset the enable register holds 4'b0010 (only transmit-empty enabled) and the transmit-empty source is pending. With `fifo_on`=0 the status word therefore reads 8'h02.
- R2: Status bit 0 is 0 when at least one enabled source is pending and 1 when none is.
- R3: Priority runs from highest to lowest: line status (enable bit 2, code 3'b011), receive (enable bit 0), transmit empty (enable bit 1, code 3'b001), modem status (enable bit 3, code 3'b000). The code of the winning source appears on status bits 3:1, and bits 5:4 always read 0.
- R4: Receive-data (code 3'b010) and receive-timeout (code 3'b110) share one level. When both are active, the data code is reported.
- R5: Status bits 7:6 both equal `fifo_on`.
- R6: A read strobe in a cycle where transmit empty is the reported source clears that source from the next cycle on, which exposes any pending modem source.
- R7: A read strobe never clears line, receive or modem sources. A read that reports a higher source leaves a pending transmit-empty source intact.
- R8: A rising edge of `txe_cond` makes the transmit-empty source pending from the next cycle.
- R9: An enable write with bit 1 set while `txe_cond` is 1 makes the transmit-empty source pending from the next cycle. The same write while `txe_cond` is 0 does not.
- R10: When `txe_cond` is 0 at a clock edge, the transmit-empty source is not pending in the following cycle.
- R11: `irq` is 1 exactly when `irq_oe` is 1 and status bit 0 is 0.
- R12: A source whose enable bit is 0 is neither reported in the status word nor able to raise `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_cond | input | 1 | Raw line-status error condition |
| rx_trig | input | 1 | Receive FIFO at or above trigger level |
| rx_tmo | input | 1 | Receive timeout condition |
| txe_cond | input | 1 | Transmit holding register / FIFO empty |
| modem_cond | input | 1 | Modem status change condition |
| ier_wr | input | 1 | Enable-register write strobe |
| ier_wdata | input | 4 | Enable-register write value |
| fifo_on | input | 1 | FIFOs enabled |
| irq_oe | input | 1 | Interrupt output enable |
| isr_rd | input | 1 | Status read strobe |
| isr_val | output | 8 | Status word |
| irq | output | 1 | Active-high interrupt |

## Verification
The hardest state to reach is the one where the transmit-empty latch disagrees with its raw condition: empty is high but the latch is clear because a read acknowledged it. The bench gets there by first reporting transmit empty, then pulsing a read. From that state it shows that only a low-then-high pulse on `txe_cond`, or an enabling write, sets the latch again. It also makes the read land while a higher source is reported, to show that the latch survives such a read.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int LVL_N  = 4;
  localparam int CODE_W = 3;
  localparam int IER_W  = 4;

  // level index, 0 = highest priority
  localparam int LVL_LINE  = 0;
  localparam int LVL_RX    = 1;
  localparam int LVL_TXE   = 2;
  localparam int LVL_MODEM = 3;

  localparam logic [CODE_W-1:0] CODE_LINE  = 3'b011;
  localparam logic [CODE_W-1:0] CODE_RXD   = 3'b010;
  localparam logic [CODE_W-1:0] CODE_RXTMO = 3'b110;
  localparam logic [CODE_W-1:0] CODE_TXE   = 3'b001;
  localparam logic [CODE_W-1:0] CODE_MODEM = 3'b000;

  localparam logic [IER_W-1:0] IER_RESET = 4'b0010;

  function automatic int ier_bit_of(input int lvl);
    case (lvl)
      LVL_LINE:  return 2;
      LVL_RX:    return 0;
      LVL_TXE:   return 1;
      default:   return 3;
    endcase
  endfunction
endpackage

// File: rtl/uirq_txe_latch.sv
module uirq_txe_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  input  logic arm_wr,
  input  logic ack,
  output logic pend
);
  logic cond_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_d <= 1'b1;
      pend   <= 1'b1;
    end else begin
      cond_d <= cond;
      if (!cond)
        pend <= 1'b0;
      else if (arm_wr || !cond_d)
        pend <= 1'b1;
      else if (ack)
        pend <= 1'b0;
    end
  end
endmodule

// File: rtl/uirq_prio_enc.sv
module uirq_prio_enc #(
  parameter int N = 4,
  parameter int W = 3
) (
  input  logic [N-1:0]   req,
  input  logic [N*W-1:0] codes,
  output logic           hit,
  output logic [N-1:0]   grant,
  output logic [W-1:0]   code
);
  always_comb begin
    hit   = 1'b0;
    grant = '0;
    code  = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (req[i]) begin
        hit   = 1'b1;
        grant = '0;
        grant[i] = 1'b1;
        code  = codes[i*W +: W];
      end
    end
  end
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_cond,
  input  logic             rx_trig,
  input  logic             rx_tmo,
  input  logic             txe_cond,
  input  logic             modem_cond,
  input  logic             ier_wr,
  input  logic [IER_W-1:0] ier_wdata,
  input  logic             fifo_on,
  input  logic             irq_oe,
  input  logic             isr_rd,
  output logic [7:0]       isr_val,
  output logic             irq
);
  localparam int TXE_BIT = ier_bit_of(LVL_TXE);

  logic [IER_W-1:0]        ier_q;
  logic                    txe_pend;
  logic [LVL_N-1:0]        raw;
  logic [LVL_N-1:0]        req;
  logic [LVL_N-1:0]        grant;
  logic [LVL_N*CODE_W-1:0] codes;
  logic                    hit;
  logic [CODE_W-1:0]       code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ier_q <= IER_RESET;
    else if (ier_wr)
      ier_q <= ier_wdata;
  end

  uirq_txe_latch u_txe (
    .clk    (clk),
    .rst_n  (rst_n),
    .cond   (txe_cond),
    .arm_wr (ier_wr && ier_wdata[TXE_BIT]),
    .ack    (isr_rd && grant[LVL_TXE]),
    .pend   (txe_pend)
  );

  always_comb begin
    raw             = '0;
    raw[LVL_LINE]   = line_cond;
    raw[LVL_RX]     = rx_trig || rx_tmo;
    raw[LVL_TXE]    = txe_pend;
    raw[LVL_MODEM]  = modem_cond;
    codes = '0;
    codes[LVL_LINE*CODE_W  +: CODE_W] = CODE_LINE;
    codes[LVL_RX*CODE_W    +: CODE_W] = rx_trig ? CODE_RXD : CODE_RXTMO;
    codes[LVL_TXE*CODE_W   +: CODE_W] = CODE_TXE;
    codes[LVL_MODEM*CODE_W +: CODE_W] = CODE_MODEM;
  end

  for (genvar g = 0; g < LVL_N; g++) begin : g_mask
    assign req[g] = raw[g] && ier_q[ier_bit_of(g)];
  end

  uirq_prio_enc #(.N(LVL_N), .W(CODE_W)) u_enc (
    .req   (req),
    .codes (codes),
    .hit   (hit),
    .grant (grant),
    .code  (code)
  );

  assign isr_val = {fifo_on, fifo_on, 2'b00, code, !hit};
  assign irq     = irq_oe && hit;
endmodule

// File: rtl/uirq_chk.sv
module uirq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       line_cond,
  input logic       txe_cond,
  input logic       ier_wr,
  input logic       irq_oe,
  input logic       isr_rd,
  input logic [3:0] ier_q,
  input logic [7:0] isr_val,
  input logic       irq
);
  // R11
  irq_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_oe |-> !irq);

  // R2
  irq_means_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !isr_val[0]);

  // R3
  line_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_cond && ier_q[2]) |-> (isr_val[3:0] == 4'b0110));

  // R6
  txe_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_rd && !ier_wr && isr_val[3:0] == 4'b0010) |=> (isr_val[3:0] != 4'b0010));

  // R10
  txe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !txe_cond |=> (isr_val[3:0] != 4'b0010));

  // R3
  zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    isr_val[5:4] == 2'b00);
endmodule

bind uart_irq_status uirq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .line_cond (line_cond),
  .txe_cond  (txe_cond),
  .ier_wr    (ier_wr),
  .irq_oe    (irq_oe),
  .isr_rd    (isr_rd),
  .ier_q     (ier_q),
  .isr_val   (isr_val),
  .irq       (irq)
);

// File: tb/sim_uart_irq_status.sv
module sim_uart_irq_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_cond = 0, rx_trig = 0, rx_tmo = 0, txe_cond = 1, modem_cond = 0;
  logic       ier_wr = 0, fifo_on = 0, irq_oe = 1, isr_rd = 0;
  logic [3:0] ier_wdata = '0;
  logic [7:0] isr_val;
  logic       irq;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  uart_irq_status u0 (
    .clk(clk), .rst_n(rst_n), .line_cond(line_cond), .rx_trig(rx_trig),
    .rx_tmo(rx_tmo), .txe_cond(txe_cond), .modem_cond(modem_cond),
    .ier_wr(ier_wr), .ier_wdata(ier_wdata), .fifo_on(fifo_on),
    .irq_oe(irq_oe), .isr_rd(isr_rd), .isr_val(isr_val), .irq(irq)
  );

  function automatic logic [7:0] model(input logic [3:0] ie, input logic ln,
      input logic tg, input logic to, input logic tp, input logic md, input logic fo);
    logic [2:0] c; logic any;
    any = 1'b1; c = 3'b000;
    if (ie[2] && ln)             c = 3'b011;
    else if (ie[0] && (tg || to)) c = tg ? 3'b010 : 3'b110;
    else if (ie[1] && tp)        c = 3'b001;
    else if (ie[3] && md)        c = 3'b000;
    else                         any = 1'b0;
    return {fo, fo, 2'b00, c, !any};
  endfunction

  task automatic chk(input string tag, input logic [7:0] e_isr, input logic e_irq);
    n_chk++;
    if (isr_val !== e_isr || irq !== e_irq) begin
      n_bad++;
      $display("FAIL %s: isr=%h irq=%b expected isr=%h irq=%b", tag, isr_val, irq, e_isr, e_irq);
    end
  endtask

  task automatic wr_ier(input logic [3:0] v);
    @(negedge clk); ier_wr = 1; ier_wdata = v;
    @(negedge clk); ier_wr = 0; #1;
  endtask

  task automatic rd_isr();
    @(negedge clk); isr_rd = 1;
    @(negedge clk); isr_rd = 0; #1;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1", 8'h02, 1'b1);

    // R2 R3 R5 R11 R12 sweep: every enable value x every input pattern
    for (int ie = 0; ie < 16; ie++) begin
      wr_ier(ie[3:0]);
      for (int p = 0; p < 64; p++) begin
        @(negedge clk);
        {line_cond, rx_trig, rx_tmo, modem_cond, fifo_on, irq_oe} = p[5:0];
        #1;
        begin
          logic [7:0] e;
          e = model(ie[3:0], line_cond, rx_trig, rx_tmo, 1'b1, modem_cond, fifo_on);
          chk("R2_R3_R5_R11_R12 sweep", e, irq_oe && !e[0]);
        end
      end
    end
    @(negedge clk);
    {line_cond, rx_trig, rx_tmo, modem_cond, fifo_on, irq_oe} = 6'b000001;

    // R4 shared receive level
    wr_ier(4'b1111);
    @(negedge clk); rx_trig = 1; rx_tmo = 1; #1; chk("R4 both", 8'h04, 1'b1);
    @(negedge clk); rx_trig = 0; #1;            chk("R4 tmo", 8'h0C, 1'b1);
    @(negedge clk); rx_tmo = 0; #1;             chk("R4 none", 8'h02, 1'b1);

    // R6 read clears transmit empty, exposes modem
    @(negedge clk); modem_cond = 1; #1; chk("R6 pre", 8'h02, 1'b1);
    rd_isr();                           chk("R6 modem visible", 8'h00, 1'b1);
    // R7 read does not clear modem
    rd_isr();                           chk("R7 modem stays", 8'h00, 1'b1);
    @(negedge clk); modem_cond = 0; #1; chk("R7 idle", 8'h01, 1'b0);

    // R9 rearm by enable write while empty
    wr_ier(4'b1111);                    chk("R9 rearm", 8'h02, 1'b1);
    // R7 read while line status reported keeps transmit empty
    @(negedge clk); line_cond = 1; #1;  chk("R7 line", 8'h06, 1'b1);
    rd_isr();                           chk("R7 line stays", 8'h06, 1'b1);
    @(negedge clk); line_cond = 0; #1;  chk("R7 txe kept", 8'h02, 1'b1);

    // R8 rising edge rearm
    rd_isr();                           chk("R8 cleared", 8'h01, 1'b0);
    repeat (3) @(negedge clk); #1;      chk("R8 no rise no rearm", 8'h01, 1'b0);
    @(negedge clk); txe_cond = 0;
    @(negedge clk); txe_cond = 1; #1;   chk("R8 before edge", 8'h01, 1'b0);
    @(negedge clk); #1;                 chk("R8 after edge", 8'h02, 1'b1);

    // R10 condition drop clears pending
    @(negedge clk); txe_cond = 0;
    @(negedge clk); #1;                 chk("R10 dropped", 8'h01, 1'b0);
    // R9 enable write while not empty does not arm
    wr_ier(4'b1111);                    chk("R9 no arm", 8'h01, 1'b0);
    @(negedge clk); txe_cond = 1;
    @(negedge clk); #1;                 chk("R8 edge again", 8'h02, 1'b1);

    // R12 disabled transmit empty is hidden; R11 gate
    wr_ier(4'b1101);                    chk("R12 masked", 8'h01, 1'b0);
    wr_ier(4'b0010);
    @(negedge clk); irq_oe = 0; #1;     chk("R11 gated", 8'h02, 1'b0);

    finish_run();
  end
endmodule